// File: doc/BRIEF.md
# Soft-Start Frequency Command Generator

This block turns a digitised feedback level into the frequency command word that sets a resonant converter's switching oscillator. A higher feedback level asks for a higher frequency. Near the bottom of the feedback range there is a dead zone in which the feedback has no effect and the command rests at the programmed minimum frequency. Above the dead zone the command rises linearly until it reaches the programmed maximum, and it stays there for any larger level. A separate, lower threshold detects a feedback path that has gone silent and raises a broken-loop flag, which a protection timer elsewhere in the chip uses.

A soft-start request places the command at the maximum frequency and then walks it down in equal steps toward the minimum. The feedback loop takes control as soon as it asks for more than the ramp value; at that point, or when the ramp reaches the floor, the soft-start status drops. The step size and the cycles between steps set how long the ramp takes. A new request during a running ramp starts it again from the top. The final command is the larger of the ramp value and the feedback value, limited to the band from minimum to maximum.

Top module: `ss_freq_cmd`

## Requirements
- R1: While reset is asserted, freqCmd, loopBroken and softActive are all 0.
- R2: With no ramp running and fbSample at or below DEAD_LVL, freqCmd equals fMinCfg one clock after the sample is presented.
- R3: With no ramp running and fbSample above DEAD_LVL, freqCmd one clock later is fMinCfg + (((fMaxCfg - fMinCfg) * d) >> SPAN_LOG2), where d is fbSample - DEAD_LVL limited to at most 2^SPAN_LOG2; for fbSample at or above DEAD_LVL + 2^SPAN_LOG2 this gives exactly fMaxCfg.
- R4: loopBroken one clock after a sample is 1 exactly when that fbSample is below FAULT_LVL.
- R5: A clock with softTrig high sets softActive and loads the ramp with fMaxCfg, so with low feedback freqCmd equals fMaxCfg one clock later.
- R6: While softActive is 1 and feedback stays below the ramp, the ramp drops by rampStep once every PRESCALE clocks, and freqCmd follows it.
- R7: When a step is due and the ramp is at most fMinCfg + rampStep, the ramp is set to fMinCfg and softActive clears on that clock.
- R8: When the feedback-derived frequency exceeds the ramp value during soft-start, softActive clears at the next clock and freqCmd follows the feedback.
- R9: A softTrig while a ramp is running restarts the ramp at fMaxCfg.
- R10: freqCmd is the larger of the ramp (only while softActive) and the feedback frequency, raised to at least fMinCfg and then limited to at most fMaxCfg; if fMinCfg exceeds fMaxCfg the command is fMaxCfg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fbSample | input | FB_W | Digitised feedback level |
| fMinCfg | input | CMD_W | Programmed minimum frequency command |
| fMaxCfg | input | CMD_W | Programmed maximum frequency command |
| softTrig | input | 1 | Soft-start request, one clock wide |
| rampStep | input | RATE_W | Amount the ramp falls at each step |
| freqCmd | output | CMD_W | Registered frequency command |
| loopBroken | output | 1 | Feedback below the fault threshold |
| softActive | output | 1 | Soft-start ramp in progress |

## Verification
The bench builds the block with an 8-bit feedback sample, a 64-code linear span starting at level 40, a fault threshold of 18, a 12-bit command and a step every 3 clocks. With these values a whole feedback sweep covers every code of the dead zone, the slope and the saturated top, and a full ramp from maximum to minimum ends within a couple of hundred clocks. Because of this, the floor snap, a restart in the middle of a ramp, the feedback taking over and an inverted min/max setting can all be run and compared against the reference model on every clock.

// File: rtl/ss_freq_pkg.sv
package ss_freq_pkg;

  // Strobes from the control sequencer to the datapath.
  typedef struct packed {
    logic loadMax;   // put the ramp at the maximum frequency
    logic stepDown;  // lower the ramp by one step
    logic snapMin;   // put the ramp at the floor
    logic rampUse;   // ramp takes part in the command selection
  } rampCtl_t;

  // Status from the datapath back to the sequencer.
  typedef struct packed {
    logic fbAbove;   // feedback frequency exceeds the ramp
    logic nearFloor; // next step would reach or pass the floor
  } rampStat_t;

endpackage

// File: rtl/ss_freq_dp.sv
module ss_freq_dp
  import ss_freq_pkg::*;
#(
  parameter int FB_W      = 10,
  parameter int CMD_W     = 16,
  parameter int RATE_W    = 12,
  parameter int DEAD_LVL  = 208,
  parameter int SPAN_LOG2 = 9,
  parameter int FAULT_LVL = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FB_W-1:0]   fbSample,
  input  logic [CMD_W-1:0]  fMinCfg,
  input  logic [CMD_W-1:0]  fMaxCfg,
  input  logic [RATE_W-1:0] rampStep,
  input  rampCtl_t          ctl,
  output rampStat_t         stat,
  output logic [CMD_W-1:0]  rampVal,
  output logic [CMD_W-1:0]  freqCmd,
  output logic              loopBroken
);

  localparam int DW  = SPAN_LOG2 + 1;
  localparam int PW  = CMD_W + DW;
  localparam int TOP_LVL = DEAD_LVL + (1 << SPAN_LOG2);
  localparam logic [FB_W:0] DEAD_V  = (FB_W+1)'(DEAD_LVL);
  localparam logic [FB_W:0] TOP_V   = (FB_W+1)'(TOP_LVL);
  localparam logic [FB_W:0] FAULT_V = (FB_W+1)'(FAULT_LVL);
  localparam logic [DW-1:0] FULL_D  = {1'b1, {SPAN_LOG2{1'b0}}};

  logic [FB_W:0]    fbExt;
  logic [DW-1:0]    delta;
  logic [CMD_W-1:0] span;
  logic [PW-1:0]    prod;
  logic [CMD_W-1:0] fbFreq;
  logic [CMD_W-1:0] selVal;
  logic [CMD_W-1:0] lowClamp;
  logic [CMD_W-1:0] cmdNext;
  logic [CMD_W-1:0] rampQ;
  logic [CMD_W:0]   floorReach;

  assign fbExt = {1'b0, fbSample};

  // Feedback to frequency: dead zone, linear slope, saturation.
  always_comb begin
    span = (fMaxCfg > fMinCfg) ? (fMaxCfg - fMinCfg) : '0;
    if (fbExt <= DEAD_V) begin
      delta = '0;
    end else if (fbExt >= TOP_V) begin
      delta = FULL_D;
    end else begin
      delta = DW'(fbExt - DEAD_V);
    end
    prod   = PW'(span) * PW'(delta);
    fbFreq = fMinCfg + CMD_W'(prod >> SPAN_LOG2);
  end

  // Larger of ramp and feedback, then limit to the band.
  always_comb begin
    selVal   = (ctl.rampUse && (rampQ > fbFreq)) ? rampQ : fbFreq;
    lowClamp = (selVal < fMinCfg) ? fMinCfg : selVal;
    cmdNext  = (lowClamp > fMaxCfg) ? fMaxCfg : lowClamp;
  end

  assign floorReach     = {1'b0, fMinCfg} + (CMD_W+1)'(rampStep);
  assign stat.fbAbove   = fbFreq > rampQ;
  assign stat.nearFloor = {1'b0, rampQ} <= floorReach;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rampQ <= '0;
    end else if (ctl.loadMax) begin
      rampQ <= fMaxCfg;
    end else if (ctl.snapMin) begin
      rampQ <= fMinCfg;
    end else if (ctl.stepDown) begin
      rampQ <= rampQ - CMD_W'(rampStep);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freqCmd    <= '0;
      loopBroken <= 1'b0;
    end else begin
      freqCmd    <= cmdNext;
      loopBroken <= fbExt < FAULT_V;
    end
  end

  assign rampVal = rampQ;

endmodule

// File: rtl/ss_freq_ctl.sv
module ss_freq_ctl
  import ss_freq_pkg::*;
#(
  parameter int PRESCALE = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      softTrig,
  input  rampStat_t stat,
  output rampCtl_t  ctl,
  output logic      softActive
);

  localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PRESCALE - 1);

  logic             activeQ;
  logic [CNT_W-1:0] cntQ;
  logic             tick;
  logic             running;

  assign tick    = (cntQ == LAST_CNT);
  assign running = activeQ && !softTrig && !stat.fbAbove;

  always_comb begin
    ctl.loadMax  = softTrig;
    ctl.stepDown = running && tick && !stat.nearFloor;
    ctl.snapMin  = running && tick && stat.nearFloor;
    ctl.rampUse  = activeQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeQ <= 1'b0;
      cntQ    <= '0;
    end else if (softTrig) begin
      activeQ <= 1'b1;
      cntQ    <= '0;
    end else if (running) begin
      if (tick) begin
        cntQ <= '0;
        if (stat.nearFloor) begin
          activeQ <= 1'b0;
        end
      end else begin
        cntQ <= cntQ + 1'b1;
      end
    end else begin
      activeQ <= 1'b0;
      cntQ    <= '0;
    end
  end

  assign softActive = activeQ;

endmodule

// File: rtl/ss_freq_cmd.sv
module ss_freq_cmd
  import ss_freq_pkg::*;
#(
  parameter int FB_W      = 10,
  parameter int CMD_W     = 16,
  parameter int RATE_W    = 12,
  parameter int DEAD_LVL  = 208,
  parameter int SPAN_LOG2 = 9,
  parameter int FAULT_LVL = 96,
  parameter int PRESCALE  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FB_W-1:0]   fbSample,
  input  logic [CMD_W-1:0]  fMinCfg,
  input  logic [CMD_W-1:0]  fMaxCfg,
  input  logic              softTrig,
  input  logic [RATE_W-1:0] rampStep,
  output logic [CMD_W-1:0]  freqCmd,
  output logic              loopBroken,
  output logic              softActive
);

  rampCtl_t         ctlStb;
  rampStat_t        dpStat;
  logic [CMD_W-1:0] rampVal;

  ss_freq_ctl #(
    .PRESCALE(PRESCALE)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .softTrig  (softTrig),
    .stat      (dpStat),
    .ctl       (ctlStb),
    .softActive(softActive)
  );

  ss_freq_dp #(
    .FB_W     (FB_W),
    .CMD_W    (CMD_W),
    .RATE_W   (RATE_W),
    .DEAD_LVL (DEAD_LVL),
    .SPAN_LOG2(SPAN_LOG2),
    .FAULT_LVL(FAULT_LVL)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .fbSample  (fbSample),
    .fMinCfg   (fMinCfg),
    .fMaxCfg   (fMaxCfg),
    .rampStep  (rampStep),
    .ctl       (ctlStb),
    .stat      (dpStat),
    .rampVal   (rampVal),
    .freqCmd   (freqCmd),
    .loopBroken(loopBroken)
  );

endmodule

// File: rtl/ss_freq_chk.sv
module ss_freq_chk #(
  parameter int FB_W      = 10,
  parameter int CMD_W     = 16,
  parameter int DEAD_LVL  = 208,
  parameter int FAULT_LVL = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic [FB_W-1:0]  fbSample,
  input logic [CMD_W-1:0] fMinCfg,
  input logic [CMD_W-1:0] fMaxCfg,
  input logic             softTrig,
  input logic [CMD_W-1:0] rampVal,
  input logic [CMD_W-1:0] freqCmd,
  input logic             loopBroken,
  input logic             softActive
);

  localparam logic [FB_W:0] DEAD_V  = (FB_W+1)'(DEAD_LVL);
  localparam logic [FB_W:0] FAULT_V = (FB_W+1)'(FAULT_LVL);

  AST_DEAD_ZONE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!softActive && ({1'b0, fbSample} <= DEAD_V) && (fMinCfg <= fMaxCfg))
      |=> (freqCmd == $past(fMinCfg))); // R2

  AST_FAULT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (loopBroken == ($past({1'b0, fbSample}) < FAULT_V))); // R4

  AST_TRIG_LOADS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    softTrig |=> (softActive && (rampVal == $past(fMaxCfg)))); // R5

  AST_RAMP_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (softActive && !softTrig && (fMinCfg <= rampVal))
      |=> (rampVal <= $past(rampVal))); // R6

  AST_CMD_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (fMinCfg <= fMaxCfg)
      |=> ((freqCmd >= $past(fMinCfg)) && (freqCmd <= $past(fMaxCfg)))); // R10

endmodule

bind ss_freq_cmd ss_freq_chk #(
  .FB_W     (FB_W),
  .CMD_W    (CMD_W),
  .DEAD_LVL (DEAD_LVL),
  .FAULT_LVL(FAULT_LVL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fbSample  (fbSample),
  .fMinCfg   (fMinCfg),
  .fMaxCfg   (fMaxCfg),
  .softTrig  (softTrig),
  .rampVal   (rampVal),
  .freqCmd   (freqCmd),
  .loopBroken(loopBroken),
  .softActive(softActive)
);

// File: tb/ss_freq_cmd_bench.sv
module ss_freq_cmd_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FB_W      = 8;
  localparam int CMD_W     = 12;
  localparam int RATE_W    = 8;
  localparam int DEAD_LVL  = 40;
  localparam int SPAN_LOG2 = 6;
  localparam int FAULT_LVL = 18;
  localparam int PRESCALE  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [FB_W-1:0]   fbSample = '0;
  logic [CMD_W-1:0]  fMinCfg = 12'd100;
  logic [CMD_W-1:0]  fMaxCfg = 12'd3000;
  logic              softTrig = 1'b0;
  logic [RATE_W-1:0] rampStep = 8'd50;
  logic [CMD_W-1:0]  freqCmd;
  logic              loopBroken;
  logic              softActive;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string curReq = "R1";
  bit done = 0;

  // reference model state
  int mCmd = 0, mBrk = 0, mAct = 0, mRamp = 0, mCnt = 0;
  bit mValid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ss_freq_cmd #(
    .FB_W(FB_W), .CMD_W(CMD_W), .RATE_W(RATE_W), .DEAD_LVL(DEAD_LVL),
    .SPAN_LOG2(SPAN_LOG2), .FAULT_LVL(FAULT_LVL), .PRESCALE(PRESCALE)
  ) u_ss_freq_cmd (
    .clk(clk), .rst_n(rst_n), .fbSample(fbSample), .fMinCfg(fMinCfg),
    .fMaxCfg(fMaxCfg), .softTrig(softTrig), .rampStep(rampStep),
    .freqCmd(freqCmd), .loopBroken(loopBroken), .softActive(softActive)
  );

  function automatic int fbToFreq(int fb, int lo, int hi);
    int spanV, d;
    spanV = (hi > lo) ? hi - lo : 0;
    if (fb <= DEAD_LVL) return lo;
    d = fb - DEAD_LVL;
    if (d > (1 << SPAN_LOG2)) d = 1 << SPAN_LOG2;
    return (lo + ((spanV * d) >> SPAN_LOG2)) % (1 << CMD_W);
  endfunction

  always @(posedge clk) begin
    int f, pick, lo, hi, fb, step;
    cycles++;
    if (!rst_n) begin
      mCmd = 0; mBrk = 0; mAct = 0; mRamp = 0; mCnt = 0;
    end else begin
      fb = int'(fbSample); lo = int'(fMinCfg); hi = int'(fMaxCfg); step = int'(rampStep);
      f = fbToFreq(fb, lo, hi);
      pick = (mAct != 0 && mRamp > f) ? mRamp : f;
      if (pick < lo) pick = lo;
      if (pick > hi) pick = hi;
      mCmd = pick;
      mBrk = (fb < FAULT_LVL) ? 1 : 0;
      if (softTrig) begin
        mAct = 1; mRamp = hi; mCnt = 0;
      end else if (mAct != 0) begin
        if (f > mRamp) begin
          mAct = 0; mCnt = 0;
        end else if (mCnt == PRESCALE - 1) begin
          mCnt = 0;
          if (mRamp <= lo + step) begin
            mRamp = lo; mAct = 0;
          end else begin
            mRamp = mRamp - step;
          end
        end else begin
          mCnt++;
        end
      end else begin
        mCnt = 0;
      end
    end
    mValid = 1;
  end

  // compare against the model on every clock
  always @(negedge clk) begin
    if (mValid && !done) begin
      checks++;
      if (int'(freqCmd) != mCmd || int'(loopBroken) != mBrk || int'(softActive) != mAct) begin
        errors++;
        $display("FAIL %s model compare: cmd=%0d brk=%0d act=%0d expected cmd=%0d brk=%0d act=%0d",
                 curReq, freqCmd, loopBroken, softActive, mCmd, mBrk, mAct);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    tick(3);
    chk("R1 reset cmd", int'(freqCmd), 0);
    chk("R1 reset broken", int'(loopBroken), 0);
    chk("R1 reset active", int'(softActive), 0);
    rst_n = 1'b1;

    // R2 dead zone
    curReq = "R2";
    for (int v = 0; v <= DEAD_LVL; v++) begin
      fbSample = FB_W'(v); tick(1);
    end
    chk("R2 at dead level", int'(freqCmd), 100);

    // R3 slope and saturation
    curReq = "R3";
    for (int v = DEAD_LVL + 1; v < 140; v++) begin
      fbSample = FB_W'(v); tick(1);
    end
    fbSample = 8'd72; tick(1);
    chk("R3 mid slope", int'(freqCmd), 1550);
    fbSample = 8'd104; tick(1);
    chk("R3 top of slope", int'(freqCmd), 3000);
    fbSample = 8'd250; tick(1);
    chk("R3 saturated", int'(freqCmd), 3000);

    // R4 broken loop threshold
    curReq = "R4";
    fbSample = 8'd17; tick(1);
    chk("R4 below fault", int'(loopBroken), 1);
    fbSample = 8'd18; tick(1);
    chk("R4 at fault", int'(loopBroken), 0);

    // R5 / R6 / R7 full ramp
    curReq = "R5";
    fbSample = 8'd30;
    softTrig = 1'b1; tick(1);
    softTrig = 1'b0;
    chk("R5 active after trigger", int'(softActive), 1);
    tick(1);
    chk("R5 command at max", int'(freqCmd), 3000);
    curReq = "R6";
    tick(3 * PRESCALE);
    chk("R6 ramp stepping", int'(freqCmd), 2850);
    curReq = "R7";
    for (int i = 0; i < 400 && softActive; i++) tick(1);
    chk("R7 ramp ended", int'(softActive), 0);
    tick(1);
    chk("R7 command at floor", int'(freqCmd), 100);

    // R9 retrigger
    curReq = "R9";
    softTrig = 1'b1; tick(1); softTrig = 1'b0;
    tick(30);
    softTrig = 1'b1; tick(1); softTrig = 1'b0;
    tick(1);
    chk("R9 restart at max", int'(freqCmd), 3000);

    // R8 feedback overtakes ramp
    curReq = "R8";
    tick(60);
    fbSample = 8'd90; tick(1);
    chk("R8 active cleared", int'(softActive), 0);
    chk("R8 command follows feedback", int'(freqCmd), 2365);
    tick(5);

    // R10 inverted band and clamp
    curReq = "R10";
    fMinCfg = 12'd500; fMaxCfg = 12'd200;
    fbSample = 8'd0; tick(2);
    chk("R10 inverted band gives max", int'(freqCmd), 200);
    fMinCfg = 12'd300; fMaxCfg = 12'd900;
    fbSample = 8'd255; tick(2);
    chk("R10 upper clamp", int'(freqCmd), 900);
    for (int v = 0; v < 256; v += 7) begin
      fbSample = FB_W'(v); tick(1);
    end
    tick(2);
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog %s: actual=timeout expected=finish", curReq);
    finishRun();
  end

endmodule